// File: doc/BRIEF.md
# Single-Accumulator Multi-Cycle Processor

This block is a small processor with an 8-bit accumulator and an 8-bit index register. It runs 16-bit instructions from one memory that holds both program and data. Each instruction word carries an opcode in its upper byte and an operand in its lower byte. The instruction set covers:

- four load flavours: immediate, direct, pointer-through-memory and index-relative;
- a register increment;
- a store;
- an unconditional jump;
- a character output strobe;
- a number input handshake;
- a stop instruction.

Every instruction starts with the same four-cycle fetch, which moves values through an address register, a data register and an instruction register. One decode/execute cycle follows, and then any memory or handshake states the opcode needs.

The controller has the states listed below. Reset enters `ST_FMAR`.

- **Fetch:** `ST_FMAR` → `ST_FINC` → `ST_FMDR` → `ST_FCIR` → `ST_EXEC`.
- **From `ST_EXEC`:**
  - immediate load, increment and jump go back to `ST_FMAR`;
  - direct and indexed loads go to `ST_DAT_WAIT`;
  - the pointer load goes to `ST_PTR_WAIT`;
  - store goes to `ST_STORE`;
  - output goes to `ST_EMIT`;
  - input goes to `ST_READ_IN`;
  - stop and any unknown opcode go to `ST_HALT`.
- **Pointer chain:** `ST_PTR_WAIT` → `ST_PTR_CAP` → `ST_PTR_MAR` → `ST_DAT_WAIT` → `ST_DAT_CAP` → `ST_DAT_LOAD` → `ST_FMAR`.
- **Single-cycle returns:** `ST_STORE` and `ST_EMIT` return to `ST_FMAR`.
- **Input wait:** `ST_READ_IN` stays put until input data is offered, then returns to `ST_FMAR`.
- **Halt:** `ST_HALT` is absorbing.

Top module: `acc_cpu`

## Requirements
- R1: The memory port is synchronous: `mem_rdata` holds the word at the `mem_addr` presented before the previous rising edge. Each instruction word has the opcode in bits 15:8 and the operand in bits 7:0. Fetch takes four cycles: address register ← PC; PC ← PC+1 while memory reads; data register ← read word; instruction register ← data register. One execute cycle follows, so the first instruction's execute cycle is cycle 5 after reset.
- R2: Opcode 0x05 loads the operand into ACC, makes no further memory access and takes 5 cycles in total.
- R3: Opcode 0x04 loads the low byte of the word at the operand address. Opcode 0x07 does the same at address (operand + IX) mod 256. Both take 8 cycles.
- R4: Opcode 0x06 reads the word at the operand address and uses its low byte as a second address. It then loads the low byte found there into ACC, and takes 11 cycles.
- R5: Opcode 0x03 adds one to ACC when the operand is 0x00, to IX when it is 0x01, and changes nothing for any other operand. Values wrap mod 256. It takes 5 cycles.
- R6: Opcode 0x10 writes {0x00, ACC} to the operand address. `mem_we` is high for exactly one cycle, the sixth cycle of the instruction. The instruction takes 6 cycles.
- R7: Opcode 0x81 raises `out_valid` for exactly one cycle, the sixth of the instruction, with `out_char` equal to ACC. It takes 6 cycles.
- R8: Opcode 0x90 holds `in_req` high from its sixth cycle until `in_valid` is high at a rising edge. It then loads `in_data` into ACC and ends with that cycle. `in_valid` at any other time has no effect.
- R9: Opcode 0xC8 loads PC with the operand and takes 5 cycles.
- R10: Opcode 0xFF raises `halted` from the cycle after its execute cycle. `halted` stays high until reset, and no further write, strobe or input request occurs.
- R11: Any opcode outside the ten listed halts in the same way as 0xFF, and also raises a sticky `illegal` flag.
- R12: While reset is held, `halted`, `illegal`, `mem_we`, `out_valid` and `in_req` are low. After reset, PC, ACC and IX are zero and fetching starts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Memory address (held address register) |
| mem_wdata | output | 16 | Store data, ACC zero-extended |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Registered memory read data |
| out_valid | output | 1 | One-cycle character strobe |
| out_char | output | 8 | Character code (ACC) |
| in_req | output | 1 | Waiting for an input number |
| in_valid | input | 1 | Input number offered |
| in_data | input | 8 | Input number |
| halted | output | 1 | Sticky stop indication |
| illegal | output | 1 | Sticky unknown-opcode indication |

## Verification
The bench steps an instruction-level reference model alongside the design and compares strobes, writes, input requests and flags on every cycle. Because the comparison is per cycle, a fetch that is one cycle short or long, or a pointer load missing its second read, shows up as a strobe or write in the wrong cycle. An indexed address that does not wrap past 255 loads the wrong character. An increment with a stray operand that touches ACC or IX changes the next printed value. A jump that falls through prints extra characters, and the total strobe count catches it. Input pulses offered outside the input instruction would change ACC if the design accepted them. An unknown opcode that does not stop the design keeps fetching and strobing past the point where the model has halted.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OP_W = 8;

    typedef enum logic [3:0] {
        ST_FMAR,
        ST_FINC,
        ST_FMDR,
        ST_FCIR,
        ST_EXEC,
        ST_PTR_WAIT,
        ST_PTR_CAP,
        ST_PTR_MAR,
        ST_DAT_WAIT,
        ST_DAT_CAP,
        ST_DAT_LOAD,
        ST_STORE,
        ST_EMIT,
        ST_READ_IN,
        ST_HALT
    } state_t;

    localparam logic [OP_W-1:0] OP_BUMP   = 8'h03;
    localparam logic [OP_W-1:0] OP_LD_DIR = 8'h04;
    localparam logic [OP_W-1:0] OP_LD_IMM = 8'h05;
    localparam logic [OP_W-1:0] OP_LD_PTR = 8'h06;
    localparam logic [OP_W-1:0] OP_LD_IDX = 8'h07;
    localparam logic [OP_W-1:0] OP_STORE  = 8'h10;
    localparam logic [OP_W-1:0] OP_EMIT   = 8'h81;
    localparam logic [OP_W-1:0] OP_ACCEPT = 8'h90;
    localparam logic [OP_W-1:0] OP_GOTO   = 8'hC8;
    localparam logic [OP_W-1:0] OP_STOP   = 8'hFF;

    function automatic logic op_known(input logic [OP_W-1:0] op);
        case (op)
            OP_BUMP, OP_LD_DIR, OP_LD_IMM, OP_LD_PTR, OP_LD_IDX,
            OP_STORE, OP_EMIT, OP_ACCEPT, OP_GOTO, OP_STOP: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/acc_cpu_fsm.sv
module acc_cpu_fsm
    import acc_cpu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OP_W-1:0]     opcode,
    input  logic                in_valid,
    output state_t              state,
    output logic                illegal
);

    state_t cur_q, nxt;
    logic   illegal_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q     <= ST_FMAR;
            illegal_q <= 1'b0;
        end else begin
            cur_q <= nxt;
            if (cur_q == ST_EXEC && !op_known(opcode))
                illegal_q <= 1'b1;
        end
    end

    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            ST_FMAR:     nxt = ST_FINC;
            ST_FINC:     nxt = ST_FMDR;
            ST_FMDR:     nxt = ST_FCIR;
            ST_FCIR:     nxt = ST_EXEC;
            ST_EXEC: begin
                case (opcode)
                    OP_LD_IMM, OP_BUMP, OP_GOTO: nxt = ST_FMAR;
                    OP_LD_DIR, OP_LD_IDX:        nxt = ST_DAT_WAIT;
                    OP_LD_PTR:                   nxt = ST_PTR_WAIT;
                    OP_STORE:                    nxt = ST_STORE;
                    OP_EMIT:                     nxt = ST_EMIT;
                    OP_ACCEPT:                   nxt = ST_READ_IN;
                    default:                     nxt = ST_HALT;
                endcase
            end
            ST_PTR_WAIT: nxt = ST_PTR_CAP;
            ST_PTR_CAP:  nxt = ST_PTR_MAR;
            ST_PTR_MAR:  nxt = ST_DAT_WAIT;
            ST_DAT_WAIT: nxt = ST_DAT_CAP;
            ST_DAT_CAP:  nxt = ST_DAT_LOAD;
            ST_DAT_LOAD: nxt = ST_FMAR;
            ST_STORE:    nxt = ST_FMAR;
            ST_EMIT:     nxt = ST_FMAR;
            ST_READ_IN:  nxt = in_valid ? ST_FMAR : ST_READ_IN;
            ST_HALT:     nxt = ST_HALT;
            default:     nxt = ST_HALT;
        endcase
    end

    assign state   = cur_q;
    assign illegal = illegal_q;

endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
    import acc_cpu_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  state_t               state,
    input  logic [OP_W+AW-1:0]   mem_rdata,
    input  logic                 in_valid,
    input  logic [AW-1:0]        in_data,
    output logic [AW-1:0]        mar,
    output logic [AW-1:0]        acc,
    output logic [OP_W-1:0]      opcode
);

    localparam int IW = OP_W + AW;

    logic [AW-1:0] pc_q, mar_q, acc_q, ix_q;
    logic [IW-1:0] mdr_q, ir_q;
    logic [AW-1:0] operand;

    assign operand = ir_q[AW-1:0];
    assign opcode  = ir_q[IW-1:AW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            mar_q <= '0;
            acc_q <= '0;
            ix_q  <= '0;
            mdr_q <= '0;
            ir_q  <= '0;
        end else begin
            case (state)
                ST_FMAR: mar_q <= pc_q;
                ST_FINC: pc_q  <= pc_q + AW'(1);
                ST_FMDR: mdr_q <= mem_rdata;
                ST_FCIR: ir_q  <= mdr_q;
                ST_EXEC: begin
                    case (opcode)
                        OP_LD_IMM: acc_q <= operand;
                        OP_LD_DIR, OP_LD_PTR, OP_STORE: mar_q <= operand;
                        OP_LD_IDX: mar_q <= operand + ix_q;
                        OP_BUMP: begin
                            if (operand == AW'(0))
                                acc_q <= acc_q + AW'(1);
                            else if (operand == AW'(1))
                                ix_q <= ix_q + AW'(1);
                        end
                        OP_GOTO: pc_q <= operand;
                        default: ;
                    endcase
                end
                ST_PTR_CAP, ST_DAT_CAP: mdr_q <= mem_rdata;
                ST_PTR_MAR:  mar_q <= mdr_q[AW-1:0];
                ST_DAT_LOAD: acc_q <= mdr_q[AW-1:0];
                ST_READ_IN:  if (in_valid) acc_q <= in_data;
                default: ;
            endcase
        end
    end

    assign mar = mar_q;
    assign acc = acc_q;

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [AW-1:0]        mem_addr,
    output logic [OP_W+AW-1:0]   mem_wdata,
    output logic                 mem_we,
    input  logic [OP_W+AW-1:0]   mem_rdata,
    output logic                 out_valid,
    output logic [AW-1:0]        out_char,
    output logic                 in_req,
    input  logic                 in_valid,
    input  logic [AW-1:0]        in_data,
    output logic                 halted,
    output logic                 illegal
);

    state_t          state;
    logic [AW-1:0]   mar, acc;
    logic [OP_W-1:0] opcode;

    acc_cpu_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode   (opcode),
        .in_valid (in_valid),
        .state    (state),
        .illegal  (illegal)
    );

    acc_cpu_datapath #(.AW(AW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .mem_rdata (mem_rdata),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .mar       (mar),
        .acc       (acc),
        .opcode    (opcode)
    );

    always_comb begin
        mem_addr  = mar;
        mem_wdata = {{OP_W{1'b0}}, acc};
        mem_we    = (state == ST_STORE);
        out_valid = (state == ST_EMIT);
        out_char  = acc;
        in_req    = (state == ST_READ_IN);
        halted    = (state == ST_HALT);
    end

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             mem_we,
    input logic [OP_W-1:0]  wdata_hi,
    input logic             out_valid,
    input logic             in_req,
    input logic             in_valid,
    input logic             halted,
    input logic             illegal
);

    p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_write_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_store_zext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wdata_hi == '0));

    p_input_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req && !in_valid) |=> in_req);

    p_input_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req && in_valid) |=> !in_req);

    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_we && !out_valid && !in_req));

    p_illegal_halts_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> halted);

    p_illegal_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal);

endmodule

bind acc_cpu acc_cpu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_we    (mem_we),
    .wdata_hi  (mem_wdata[OP_W+AW-1:AW]),
    .out_valid (out_valid),
    .in_req    (in_req),
    .in_valid  (in_valid),
    .halted    (halted),
    .illegal   (illegal)
);

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;

    localparam int AW = 8;
    localparam int WW = 16;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [WW-1:0] mem_wdata;
    logic          mem_we;
    logic [WW-1:0] mem_rdata;
    logic          out_valid;
    logic [AW-1:0] out_char;
    logic          in_req;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_data = '0;
    logic          halted;
    logic          illegal;

    always #2 clk = ~clk;

    acc_cpu #(.AW(AW)) u0 (.*);

    logic [WW-1:0] mem     [0:255];
    logic [WW-1:0] ref_mem [0:255];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    int checks = 0, errors = 0;
    int cyc = 0, total_cyc = 0, strobes = 0, first_strobe = 0;
    bit run = 0;
    int k;
    logic [7:0] m_pc, m_acc, m_ix;
    bit m_halt, m_ill;
    logic [WW-1:0] cur;
    string m_tag;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [WW-1:0] w);
        mem[a] = w;
        ref_mem[a] = w;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) put(i, '0);
    endtask

    task automatic model_reset();
        k = 1; m_pc = 0; m_acc = 0; m_ix = 0; m_halt = 0; m_ill = 0;
        cyc = 0; strobes = 0; first_strobe = 0; m_tag = "R12";
    endtask

    function automatic bit ref_known(input logic [7:0] op);
        return op == 8'h03 || op == 8'h04 || op == 8'h05 || op == 8'h06 || op == 8'h07 ||
               op == 8'h10 || op == 8'h81 || op == 8'h90 || op == 8'hC8 || op == 8'hFF;
    endfunction

    function automatic int ref_len(input logic [7:0] op);
        case (op)
            8'h04, 8'h07: return 8;
            8'h06:        return 11;
            8'h10, 8'h81: return 6;
            8'h90:        return 1000000;
            default:      return 5;
        endcase
    endfunction

    // Reference model: one instruction-level step per cycle, compared at the falling edge.
    always @(negedge clk) begin
        if (run) begin
            logic [7:0] op, opr;
            bit e_we, e_out, e_req, done;
            cyc++;
            total_cyc++;
            in_valid = (cyc % 4 == 0);
            in_data  = 8'((cyc * 7 + 3) & 255);
            if (m_halt) begin
                chk(halted == 1'b1, "R10 halted", int'(halted), 1);
                chk(illegal == m_ill, "R11 illegal", int'(illegal), int'(m_ill));
                chk(!mem_we && !out_valid && !in_req, "R10 quiet after halt",
                    int'({mem_we, out_valid, in_req}), 0);
            end else begin
                if (k == 1) cur = ref_mem[m_pc];
                op = cur[15:8];
                opr = cur[7:0];
                e_we  = (op == 8'h10) && (k == 6);
                e_out = (op == 8'h81) && (k == 6);
                e_req = (op == 8'h90) && (k >= 6);
                chk(mem_we == e_we, "R6 mem_we", int'(mem_we), int'(e_we));
                chk(out_valid == e_out, "R7 out_valid", int'(out_valid), int'(e_out));
                chk(in_req == e_req, "R8 in_req", int'(in_req), int'(e_req));
                chk(halted == 1'b0, "R10 halted early", int'(halted), 0);
                chk(illegal == 1'b0, "R11 illegal early", int'(illegal), 0);
                if (e_we) begin
                    chk(mem_addr == opr, "R6 store address", int'(mem_addr), int'(opr));
                    chk(mem_wdata == {8'h00, m_acc}, "R6 store data", int'(mem_wdata), int'(m_acc));
                end
                if (e_out) begin
                    chk(out_char == m_acc, {m_tag, " out_char"}, int'(out_char), int'(m_acc));
                end
                if (out_valid) begin
                    strobes++;
                    if (first_strobe == 0) first_strobe = cyc;
                end
                done = (op == 8'h90) ? (k >= 6 && in_valid) : (k == ref_len(op));
                if (done) begin
                    m_pc = m_pc + 8'd1;
                    case (op)
                        8'h05: begin m_acc = opr; m_tag = "R2"; end
                        8'h04: begin m_acc = ref_mem[opr][7:0]; m_tag = "R3"; end
                        8'h07: begin m_acc = ref_mem[8'(opr + m_ix)][7:0]; m_tag = "R3"; end
                        8'h06: begin m_acc = ref_mem[ref_mem[opr][7:0]][7:0]; m_tag = "R4"; end
                        8'h03: begin
                            if (opr == 8'h00) m_acc = m_acc + 8'd1;
                            else if (opr == 8'h01) m_ix = m_ix + 8'd1;
                            m_tag = "R5";
                        end
                        8'h10: ref_mem[opr] = {8'h00, m_acc};
                        8'h90: begin m_acc = in_data; m_tag = "R8"; end
                        8'hC8: m_pc = opr;
                        8'h81: ;
                        default: begin
                            m_halt = 1;
                            m_ill = !ref_known(op);
                        end
                    endcase
                    k = 1;
                end else begin
                    k++;
                end
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (total_cyc > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", total_cyc, WATCHDOG);
            finish_run();
        end
    end

    task automatic reset_phase();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!halted && !illegal && !mem_we && !out_valid && !in_req, "R12 reset outputs",
            int'({halted, illegal, mem_we, out_valid, in_req}), 0);
        model_reset();
        @(posedge clk);
        #1 rst_n = 1'b1;
        run = 1;
    endtask

    initial begin
        // Program A: exercises every opcode and the wrap corner cases.
        clear_mem();
        put(0,  16'h0541);  // R2 immediate 0x41
        put(1,  16'h8100);  // R7 output
        put(2,  16'h0440);  // R3 direct
        put(3,  16'h8100);
        put(4,  16'h0641);  // R4 pointer
        put(5,  16'h8100);
        put(6,  16'h0301);  // R5 IX+1
        put(7,  16'h0301);  // R5 IX+1
        put(8,  16'h0744);  // R3 indexed -> 0x46
        put(9,  16'h8100);
        put(10, 16'h0300);  // R5 ACC+1
        put(11, 16'h0307);  // R5 stray operand: no effect
        put(12, 16'h8100);
        put(13, 16'h1050);  // R6 store
        put(14, 16'h0500);
        put(15, 16'h0450);  // reload stored value
        put(16, 16'h8100);
        put(17, 16'h9000);  // R8 input
        put(18, 16'h8100);
        put(19, 16'h07FF);  // R3 index wrap -> address 0x01
        put(20, 16'h8100);
        put(21, 16'hC818);  // R9 jump to 24
        put(22, 16'h05EE);  // skipped
        put(23, 16'h8100);  // skipped
        put(24, 16'h0300);
        put(25, 16'h8100);
        put(26, 16'hFF00);  // R10 stop
        put(8'h40, 16'h1242);
        put(8'h41, 16'h0043);
        put(8'h43, 16'h0058);
        put(8'h46, 16'h005A);

        reset_phase();
        wait (m_halt);
        repeat (20) @(negedge clk);
        chk(first_strobe == 11, "R1 fetch timing first strobe cycle", first_strobe, 11);
        chk(strobes == 9, "R9 jump skips strobe count", strobes, 9);
        chk(mem[8'h50] == 16'h005B, "R6 stored word", int'(mem[8'h50]), 16'h005B);
        chk(halted && !illegal, "R10 stop without illegal", int'({halted, illegal}), 2);
        @(posedge clk);
        #1 run = 0;

        // Program B: unknown opcode.
        clear_mem();
        put(0, 16'h0507);
        put(1, 16'h8100);
        put(2, 16'h2A00);  // R11 unknown opcode
        put(3, 16'h8100);
        reset_phase();
        wait (m_halt);
        repeat (10) @(negedge clk);
        chk(illegal && halted, "R11 illegal and halted", int'({illegal, halted}), 3);
        chk(strobes == 1, "R11 no strobes after unknown opcode", strobes, 1);
        finish_run();
    end

endmodule